// File: doc/BRIEF.md
# Display Bridge Bring-Up Sequencer

This block takes a parallel-RGB-to-DSI bridge from power-on to running video without software stepping through it. On a `start` pulse it holds the bridge reset pin low, releases it and lets the bridge settle. If a read-back path exists, it then confirms the bridge identity. Next it programs the video timing, pixel format, lane count, configuration, PLL and clock registers. It enables the PLL and waits for lock, sends the exit-sleep and display-on commands with their configured delays, and finally switches the data lanes to high speed with the video path enabled.

Every register access goes out through a simple request/acknowledge register-access port. A separate serial-link engine serves that port and is not part of this block. The PLL control word is worked out elsewhere and arrives as an input. So does the PLL bit rate, from which this block derives the low-power clock divider. All waits come from one microsecond prescaler sized by a clock-frequency parameter. The run ends in a `done` state or an `error` state, and either one lasts until the next `start`.

Top module: `brg_bringup`

## Requirements
- R1: After `start`, `bridge_rst_n` is driven low for 10 ms and then high. There is a further 10 ms with no access before the first register access. No access is ever requested while `bridge_rst_n` is low.
- R2: When `has_rdbk` is 1, register 0xB0 is read and must return 0x2828, and then register 0xB7 is read and must return 0x0301. A mismatch stops the sequence with `error` high and no further access. When `has_rdbk` is 0, no read is issued.
- R3: The timing registers are written in this order. 0xB1 = {vsync, hsync}. 0xB2 = {vsync+vbp, hsync+hbp}, where each sum wraps to 8 bits. 0xB3 = {vfp, hfp}. 0xB4 = horizontal resolution. 0xB5 = vertical resolution.
- R4: Register 0xB6 is written with 0x0008 ORed with a format code. The code is 0 for depth 16, 1 for depth 18 with `loose18`=0, 2 for depth 18 with `loose18`=1, and 3 for depth 24. Any other depth raises `error` after the 0xB5 write, without writing 0xB6.
- R5: Register 0xDE is written with `lanes` minus one.
- R6: Register 0xB7 is then written with 0x0342, or with 0x0362 when `pclk_ref` is 1.
- R7: Register 0xBA is written with `pll_word`, then 0xB8 with 0, then 0xBB with (ceil(`pll_kbps`/80000) − 1) & 0x3F, then 0xB9 with 1. At least 500 µs pass before the next access.
- R8: Each display command is two writes: 1 to 0xBC, then the command byte to 0xBF. Exit-sleep (0x11) is sent first and is followed by `sleep_ms` ms. Display-on (0x29) is sent second and is followed by `on_ms` ms.
- R9: Last, register 0xB7 is written with the R6 value ORed with 0x0009, and `done` rises.
- R10: `acc_req` stays high with `acc_wr`, `acc_addr` and `acc_wdata` stable until `acc_ack`. Each acknowledge completes exactly one access.
- R11: `done` and `error` are never high together. Each holds until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the bring-up (accepted when not running) |
| has_rdbk | input | 1 | A read-back path exists; enables the identity check |
| pclk_ref | input | 1 | Pixel clock is the PLL reference |
| hsync | input | 8 | Horizontal sync width |
| vsync | input | 8 | Vertical sync width |
| hbp | input | 8 | Horizontal back porch |
| vbp | input | 8 | Vertical back porch |
| hfp | input | 8 | Horizontal front porch |
| vfp | input | 8 | Vertical front porch |
| hres | input | 16 | Horizontal resolution |
| vres | input | 16 | Vertical resolution |
| depth | input | 6 | Colour depth in bits per pixel |
| loose18 | input | 1 | Loosely packed 18 bpp format |
| lanes | input | 3 | Number of data lanes (1..4) |
| pll_word | input | 16 | Precomputed PLL control word |
| pll_kbps | input | 20 | PLL bit rate in kbit/s |
| sleep_ms | input | 8 | Delay after exit-sleep, ms |
| on_ms | input | 8 | Delay after display-on, ms |
| acc_req | output | 1 | Register access request |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_addr | output | 8 | Register address |
| acc_wdata | output | 16 | Write data |
| acc_ack | input | 1 | Access complete (one-cycle pulse) |
| acc_rdata | input | 16 | Read data, valid with `acc_ack` |
| bridge_rst_n | output | 1 | Bridge reset pin, active low |
| done | output | 1 | Bring-up finished |
| error | output | 1 | Bring-up aborted |

## Verification
The assertions assume that the configuration inputs stay constant from `start` until `done` or `error`. They also assume that `acc_ack` only arrives while `acc_req` is high and lasts one cycle per access, and that `lanes` is at least one. The stimulus sets every configuration input before pulsing `start` and changes none of them until the run has ended. The responder model raises a single acknowledge one to three cycles after it sees a request, and it drops the acknowledge before any new request can appear. The configurations sweep every colour-depth code, both reference choices, both read-back settings, divider values that land on and just past a boundary, and timing sums that wrap. They also include an invalid depth and a wrong identity.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int unsigned STEP_W  = 5;
  localparam int unsigned US_W    = 18;
  localparam int unsigned RST_US  = 10000;
  localparam int unsigned LOCK_US = 500;
  localparam int unsigned LP_KBPS = 80000;

  typedef enum logic [1:0] {K_WAIT, K_WR, K_RD, K_END} kind_t;
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ACC, S_WAIT, S_DONE, S_FAIL} st_t;

  typedef struct packed {
    logic        has_rdbk;
    logic        pclk_ref;
    logic [7:0]  hsync, vsync, hbp, vbp, hfp, vfp;
    logic [15:0] hres, vres;
    logic [5:0]  depth;
    logic        loose18;
    logic [2:0]  lanes;
    logic [15:0] pll_word;
    logic [19:0] pll_kbps;
    logic [7:0]  sleep_ms, on_ms;
  } cfg_t;
endpackage

// File: rtl/brg_wait_timer.sv
module brg_wait_timer import brg_pkg::*; #(
  parameter int unsigned CYC_PER_US = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [US_W-1:0] load_us,
  output logic            expired
);
  localparam int unsigned PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);

  logic [PW-1:0]   pre_q, pre_d;
  logic [US_W-1:0] cnt_q, cnt_d;
  logic            tick;

  assign tick = (pre_q == PRE_LAST);

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (load) begin
      pre_d = '0;
      cnt_d = load_us;
    end else if (cnt_q != '0) begin
      pre_d = tick ? '0 : pre_q + PW'(1);
      if (tick) cnt_d = cnt_q - US_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // R7
  cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/brg_step_table.sv
module brg_step_table import brg_pkg::*; (
  input  logic [STEP_W-1:0] step,
  input  cfg_t              cfg,
  output kind_t             kind,
  output logic [7:0]        addr,
  output logic [15:0]       data,
  output logic [US_W-1:0]   wait_us,
  output logic              skip,
  output logic              bad
);
  logic [1:0]  fmt;
  logic        fmt_ok;
  logic [20:0] lp_div;
  logic [15:0] cfg_a;

  always_comb begin
    fmt_ok = 1'b1;
    fmt    = 2'd0;
    case (cfg.depth)
      6'd16:   fmt = 2'd0;
      6'd18:   fmt = cfg.loose18 ? 2'd2 : 2'd1;
      6'd24:   fmt = 2'd3;
      default: fmt_ok = 1'b0;
    endcase
  end

  assign lp_div = (21'(cfg.pll_kbps) + 21'(LP_KBPS - 1)) / 21'(LP_KBPS);
  assign cfg_a  = 16'h0342 | (cfg.pclk_ref ? 16'h0020 : 16'h0000);

  always_comb begin
    kind    = K_WR;
    addr    = 8'h00;
    data    = 16'h0000;
    wait_us = '0;
    skip    = 1'b0;
    bad     = 1'b0;
    case (step)
      5'd0:  begin kind = K_WAIT; wait_us = US_W'(RST_US); end
      5'd1:  begin kind = K_WAIT; wait_us = US_W'(RST_US); end
      5'd2:  begin kind = K_RD; addr = 8'hB0; data = 16'h2828; skip = !cfg.has_rdbk; end
      5'd3:  begin kind = K_RD; addr = 8'hB7; data = 16'h0301; skip = !cfg.has_rdbk; end
      5'd4:  begin addr = 8'hB1; data = {cfg.vsync, cfg.hsync}; end
      5'd5:  begin addr = 8'hB2; data = {8'(cfg.vsync + cfg.vbp), 8'(cfg.hsync + cfg.hbp)}; end
      5'd6:  begin addr = 8'hB3; data = {cfg.vfp, cfg.hfp}; end
      5'd7:  begin addr = 8'hB4; data = cfg.hres; end
      5'd8:  begin addr = 8'hB5; data = cfg.vres; end
      5'd9:  begin addr = 8'hB6; data = 16'h0008 | 16'(fmt); bad = !fmt_ok; end
      5'd10: begin addr = 8'hDE; data = 16'(cfg.lanes - 3'd1); end
      5'd11: begin addr = 8'hB7; data = cfg_a; end
      5'd12: begin addr = 8'hBA; data = cfg.pll_word; end
      5'd13: begin addr = 8'hB8; data = 16'h0000; end
      5'd14: begin addr = 8'hBB; data = 16'((lp_div - 21'd1) & 21'h3F); end
      5'd15: begin addr = 8'hB9; data = 16'h0001; end
      5'd16: begin kind = K_WAIT; wait_us = US_W'(LOCK_US); end
      5'd17: begin addr = 8'hBC; data = 16'h0001; end
      5'd18: begin addr = 8'hBF; data = 16'h0011; end
      5'd19: begin kind = K_WAIT; wait_us = US_W'(cfg.sleep_ms) * US_W'(1000); end
      5'd20: begin addr = 8'hBC; data = 16'h0001; end
      5'd21: begin addr = 8'hBF; data = 16'h0029; end
      5'd22: begin kind = K_WAIT; wait_us = US_W'(cfg.on_ms) * US_W'(1000); end
      5'd23: begin addr = 8'hB7; data = cfg_a | 16'h0009; end
      default: kind = K_END;
    endcase
  end
endmodule

// File: rtl/brg_bringup.sv
module brg_bringup import brg_pkg::*; #(
  parameter int unsigned CLK_KHZ = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        has_rdbk,
  input  logic        pclk_ref,
  input  logic [7:0]  hsync,
  input  logic [7:0]  vsync,
  input  logic [7:0]  hbp,
  input  logic [7:0]  vbp,
  input  logic [7:0]  hfp,
  input  logic [7:0]  vfp,
  input  logic [15:0] hres,
  input  logic [15:0] vres,
  input  logic [5:0]  depth,
  input  logic        loose18,
  input  logic [2:0]  lanes,
  input  logic [15:0] pll_word,
  input  logic [19:0] pll_kbps,
  input  logic [7:0]  sleep_ms,
  input  logic [7:0]  on_ms,
  output logic        acc_req,
  output logic        acc_wr,
  output logic [7:0]  acc_addr,
  output logic [15:0] acc_wdata,
  input  logic        acc_ack,
  input  logic [15:0] acc_rdata,
  output logic        bridge_rst_n,
  output logic        done,
  output logic        error
);
  localparam int unsigned CYC_PER_US = (CLK_KHZ >= 2000) ? CLK_KHZ / 1000 : 1;

  st_t               st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  cfg_t              cfg;
  kind_t             kind;
  logic [15:0]       data;
  logic [US_W-1:0]   wait_us;
  logic              skip, bad, tload, expired;

  assign cfg = '{has_rdbk: has_rdbk, pclk_ref: pclk_ref, hsync: hsync, vsync: vsync,
                 hbp: hbp, vbp: vbp, hfp: hfp, vfp: vfp, hres: hres, vres: vres,
                 depth: depth, loose18: loose18, lanes: lanes, pll_word: pll_word,
                 pll_kbps: pll_kbps, sleep_ms: sleep_ms, on_ms: on_ms};

  brg_step_table u_tbl (
    .step(step_q), .cfg(cfg), .kind(kind), .addr(acc_addr), .data(data),
    .wait_us(wait_us), .skip(skip), .bad(bad)
  );

  brg_wait_timer #(.CYC_PER_US(CYC_PER_US)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tload), .load_us(wait_us), .expired(expired)
  );

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    tload  = 1'b0;
    case (st_q)
      S_IDLE, S_DONE, S_FAIL: if (start) begin
        st_d   = S_LOAD;
        step_d = '0;
      end
      S_LOAD: begin
        if (skip) step_d = step_q + STEP_W'(1);
        else if (bad) st_d = S_FAIL;
        else case (kind)
          K_WAIT: begin tload = 1'b1; st_d = S_WAIT; end
          K_END:  st_d = S_DONE;
          default: st_d = S_ACC;
        endcase
      end
      S_ACC: if (acc_ack) begin
        if (kind == K_RD && acc_rdata != data) st_d = S_FAIL;
        else begin
          st_d   = S_LOAD;
          step_d = step_q + STEP_W'(1);
        end
      end
      S_WAIT: if (expired) begin
        st_d   = S_LOAD;
        step_d = step_q + STEP_W'(1);
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

  assign acc_req      = (st_q == S_ACC);
  assign acc_wr       = (kind == K_WR);
  assign acc_wdata    = (kind == K_WR) ? data : 16'h0000;
  assign done         = (st_q == S_DONE);
  assign error        = (st_q == S_FAIL);
  assign bridge_rst_n = !((st_q == S_LOAD || st_q == S_WAIT) && step_q == '0);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_ack) |=> (acc_req && $stable(acc_addr) && $stable(acc_wdata) && $stable(acc_wr)));
  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_rst_n |-> !acc_req);
  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);
  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: tb/sim_brg_bringup.sv
module sim_brg_bringup;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic has_rdbk, pclk_ref, loose18;
  logic [7:0]  hsync, vsync, hbp, vbp, hfp, vfp, sleep_ms, on_ms;
  logic [15:0] hres, vres, pll_word;
  logic [5:0]  depth;
  logic [2:0]  lanes;
  logic [19:0] pll_kbps;
  logic acc_req, acc_wr, acc_ack, bridge_rst_n, done, error;
  logic [7:0]  acc_addr;
  logic [15:0] acc_wdata, acc_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lowcnt = 0;
  int lat    = 0;
  int dly    = 0;
  logic [15:0] id_val = 16'h2828;

  logic        log_wr [32];
  logic [7:0]  log_a  [32];
  logic [15:0] log_d  [32];
  int          log_t  [32];
  int          nlog = 0;

  logic        exp_wr [32];
  logic [7:0]  exp_a  [32];
  logic [15:0] exp_d  [32];
  int          nexp = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!bridge_rst_n) lowcnt <= lowcnt + 1;

  brg_bringup #(.CLK_KHZ(1000)) u0 (.*);

  // Responder model for the register-access port
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_ack <= 1'b0; acc_rdata <= 16'h0; dly <= 0;
    end else if (acc_req && !acc_ack) begin
      if (dly >= lat) begin
        acc_ack <= 1'b1;
        dly     <= 0;
        acc_rdata <= (acc_addr == 8'hB0) ? id_val : (acc_addr == 8'hB7) ? 16'h0301 : 16'h0;
        if (nlog < 32) begin
          log_wr[nlog] <= acc_wr; log_a[nlog] <= acc_addr;
          log_d[nlog]  <= acc_wr ? acc_wdata : 16'h0; log_t[nlog] <= cyc;
        end
        nlog <= nlog + 1;
      end else dly <= dly + 1;
    end else acc_ack <= 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic w, input logic [7:0] a, input logic [15:0] d);
    exp_wr[nexp] = w; exp_a[nexp] = a; exp_d[nexp] = d; nexp++;
  endtask

  function automatic int fmt_code(input int dp, input logic lo);
    if (dp == 16) return 0;
    if (dp == 18) return lo ? 2 : 1;
    if (dp == 24) return 3;
    return -1;
  endfunction

  task automatic build_exp(input bit id_ok);
    int lp;
    logic [15:0] c1;
    nexp = 0;
    if (has_rdbk) begin
      push(1'b0, 8'hB0, 16'h0);
      if (!id_ok) return;
      push(1'b0, 8'hB7, 16'h0);
    end
    push(1'b1, 8'hB1, {vsync, hsync});
    push(1'b1, 8'hB2, {8'((vsync + vbp) % 256), 8'((hsync + hbp) % 256)});
    push(1'b1, 8'hB3, {vfp, hfp});
    push(1'b1, 8'hB4, hres);
    push(1'b1, 8'hB5, vres);
    if (fmt_code(int'(depth), loose18) < 0) return;
    push(1'b1, 8'hB6, 16'(8 + fmt_code(int'(depth), loose18)));
    push(1'b1, 8'hDE, 16'(int'(lanes) - 1));
    c1 = pclk_ref ? 16'h0362 : 16'h0342;
    push(1'b1, 8'hB7, c1);
    push(1'b1, 8'hBA, pll_word);
    push(1'b1, 8'hB8, 16'h0);
    lp = (int'(pll_kbps) + 79999) / 80000;
    push(1'b1, 8'hBB, 16'((lp - 1) & 63));
    push(1'b1, 8'hB9, 16'h1);
    push(1'b1, 8'hBC, 16'h1);
    push(1'b1, 8'hBF, 16'h11);
    push(1'b1, 8'hBC, 16'h1);
    push(1'b1, 8'hBF, 16'h29);
    push(1'b1, 8'hB7, c1 | 16'h0009);
  endtask

  task automatic run(input bit expect_err, input bit id_ok);
    int t0;
    build_exp(id_ok);
    @(negedge clk);
    nlog = 0; lowcnt = 0; t0 = cyc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && !error) @(negedge clk);
    repeat (20) @(negedge clk);
    // R11: final status held and exclusive
    check(done == !expect_err && error == expect_err, "R11", {done, error}, {!expect_err, expect_err});
    // R1: reset pulse length and settle time
    check(lowcnt >= 10000 && lowcnt <= 10004, "R1", lowcnt, 10000);
    if (nlog > 0) check(log_t[0] - t0 >= 20000, "R1", log_t[0] - t0, 20000);
    // R2 R3 R4 R5 R6 R7 R8 R9 R10: access sequence
    check(nlog == nexp, "R10", nlog, nexp);
    for (int i = 0; i < nexp && i < nlog; i++) begin
      check(log_wr[i] == exp_wr[i] && log_a[i] == exp_a[i] && log_d[i] == exp_d[i],
            exp_wr[i] ? "R3-R9 write" : "R2 read", {log_a[i], log_d[i]}, {exp_a[i], exp_d[i]});
    end
    if (!expect_err && nlog == nexp) begin
      for (int i = 0; i < nlog; i++) begin
        // R7: lock wait after PLL enable
        if (log_a[i] == 8'hB9) check(log_t[i+1] - log_t[i] >= 500, "R7", log_t[i+1] - log_t[i], 500);
        // R8: delays after each command
        if (log_a[i] == 8'hBF && log_d[i] == 16'h11)
          check(log_t[i+1] - log_t[i] >= int'(sleep_ms) * 1000, "R8", log_t[i+1] - log_t[i], int'(sleep_ms) * 1000);
        if (log_a[i] == 8'hBF && log_d[i] == 16'h29)
          check(log_t[i+1] - log_t[i] >= int'(on_ms) * 1000, "R8", log_t[i+1] - log_t[i], int'(on_ms) * 1000);
      end
    end
  endtask

  task automatic setup(input bit rb, input bit pr, input int dp, input bit lo, input int ln,
                       input int kb, input int sm, input int om, input int l);
    has_rdbk = rb; pclk_ref = pr; depth = 6'(dp); loose18 = lo; lanes = 3'(ln);
    pll_kbps = 20'(kb); sleep_ms = 8'(sm); on_ms = 8'(om); lat = l;
    pll_word = 16'(16'h4000 + kb[15:0]);
  endtask

  initial begin
    hsync = 8'd10; vsync = 8'd4; hbp = 8'd20; vbp = 8'd6; hfp = 8'd30; vfp = 8'd8;
    hres = 16'd800; vres = 16'd480;
    setup(1, 0, 24, 0, 4, 400000, 1, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 R1: idle state after reset
    check(!done && !error && !acc_req && bridge_rst_n, "R11 reset", {done, error, acc_req, bridge_rst_n}, 4'b0001);

    run(0, 1);
    setup(0, 1, 16, 0, 1, 80001, 0, 1, 2);
    hres = 16'd1280; vres = 16'd720;
    run(0, 1);
    setup(1, 1, 18, 1, 2, 0, 0, 0, 1);
    run(0, 1);
    setup(0, 0, 18, 0, 3, 80000, 0, 0, 0);
    hsync = 8'd200; hbp = 8'd100; vsync = 8'd250; vbp = 8'd9;
    run(0, 1);
    // R4: invalid depth aborts after 0xB5
    setup(0, 0, 20, 0, 2, 160000, 0, 0, 1);
    run(1, 1);
    // R2: identity mismatch aborts after first read
    setup(1, 0, 24, 0, 4, 400000, 0, 0, 0);
    id_val = 16'h2827;
    run(1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule